// File: doc/BRIEF.md
# Bus Memory Protection Checker

The checker sits beside one bus slave port and judges every address-phase transfer against a bank of programmable region descriptors. Each descriptor names an inclusive address span with 32-byte granularity, a set of access rights, and an enable flag. When a transfer arrives, every enabled descriptor compares the address against its lower and upper bound in parallel. Each descriptor that matches then tests the right the transfer needs, given the requesting master, its privilege level and the access kind. The transfer is allowed when at least one matching descriptor grants that right. Otherwise the checker flags a protection error.

The verdict is registered and appears one cycle after the transfer is presented. The slave logic can then use it to launch a two-cycle error response in the data phase. Software programs the descriptors through a simple write port, one 32-bit word at a time. Any edit to the bounds or to the rights disables the descriptor until software enables it again explicitly. A half-edited region therefore never takes effect.

Top module: `bus_prot_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, resp_valid_o and resp_err_o are 0. After reset every descriptor is disabled, so every access reports an error until a descriptor is enabled.
- R2: A descriptor matches when it is enabled and lo <= addr[31:5] <= hi. Word 0 bits [31:5] hold lo and word 1 bits [31:5] hold hi. Address bits [4:0] play no part, so both bounds are inclusive at 32-byte granularity.
- R3: A master whose ID is below NUM_CPU is a processor. For a processor, word 2 bit 0, bit 1 and bit 2 give the read, write and fetch rights of supervisor accesses (acc_super_i=1). Bits 3, 4 and 5 give the same rights for user accesses.
- R4: For any other master, word 2 bit 6 gives the read right and bit 7 the write right, whatever acc_super_i is. An instruction fetch from such a master needs bit 6.
- R5: An access that matches no enabled descriptor, or matches only descriptors that lack the needed right, reports resp_err_o=1.
- R6: When several enabled descriptors match, the access is allowed if any one of them grants the needed right.
- R7: cfg_addr_i = {region index, word[1:0]}. A write to word 0, 1 or 2 disables that descriptor. A write to word 3 sets the enable flag to cfg_wdata_i[0].
- R8: resp_valid_o is acc_valid_i delayed by one cycle. resp_err_o carries the verdict for that transfer and is 0 whenever resp_valid_o is 0.
- R9: acc_type_i encodes 0 as read, 1 as write, 2 as instruction fetch and 3 as reserved. A reserved type always reports an error.
- R10: Writes whose region index is NUM_RGN or above change no descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Descriptor word write strobe |
| cfg_addr_i | input | $clog2(NUM_RGN)+2 | Region index and word select |
| cfg_wdata_i | input | 32 | Descriptor word write data |
| acc_valid_i | input | 1 | Address-phase transfer present |
| acc_addr_i | input | 32 | Transfer byte address |
| acc_master_i | input | MID_W | Requesting master ID |
| acc_super_i | input | 1 | 1 = supervisor, 0 = user |
| acc_type_i | input | 2 | Access kind, encoded as in R9 |
| resp_valid_o | output | 1 | Verdict present, one cycle after the transfer |
| resp_err_o | output | 1 | Protection error for that transfer |

## Verification
The hardest case to reach is a transfer that lands where overlapping descriptors disagree. One of them grants the right and a neighbour denies it, or one of the pair has just been disabled by a bound edit. The bench builds a staircase of regions in which each region overlaps the next, with rights that differ from region to region and one region left disabled. It then sweeps every master, privilege and access kind across each region's edges, interior and overlap. A second sweep disables a region by rewriting one of its bounds, and the bench compares the verdicts there with those after the region is enabled again.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int WORD_W   = 32;
  localparam int GRAN_LSB = 5;
  localparam int PERM_W   = 8;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_type_e;

  typedef struct packed {
    logic [WORD_W-1:GRAN_LSB] lo;
    logic [WORD_W-1:GRAN_LSB] hi;
    logic [PERM_W-1:0]        perm;
    logic                     vld;
  } rgn_t;
endpackage

// File: rtl/bpc_rgn_store.sv
module bpc_rgn_store
  import bpc_pkg::*;
#(
  parameter int NUM_RGN = 12,
  parameter int CFG_AW  = $clog2(NUM_RGN) + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [CFG_AW-1:0]      addr_i,
  input  logic [WORD_W-1:0]      wdata_i,
  output rgn_t [NUM_RGN-1:0]     rgn_o
);
  localparam int IDX_W = CFG_AW - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       wsel;
  assign idx  = addr_i[CFG_AW-1:2];
  assign wsel = addr_i[1:0];

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic wr_hit;
    rgn_t rgn_q;
    // indices at or above NUM_RGN match no slot
    assign wr_hit = we_i && (idx == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rgn_q <= '0;
      end else if (wr_hit) begin
        unique case (wsel)
          2'd0: begin rgn_q.lo   <= wdata_i[WORD_W-1:GRAN_LSB]; rgn_q.vld <= 1'b0; end
          2'd1: begin rgn_q.hi   <= wdata_i[WORD_W-1:GRAN_LSB]; rgn_q.vld <= 1'b0; end
          2'd2: begin rgn_q.perm <= wdata_i[PERM_W-1:0];        rgn_q.vld <= 1'b0; end
          default: rgn_q.vld <= wdata_i[0];
        endcase
      end
    end
    assign rgn_o[g] = rgn_q;
  end
endmodule

// File: rtl/bpc_rgn_eval.sv
module bpc_rgn_eval
  import bpc_pkg::*;
#(
  parameter int NUM_RGN = 12,
  parameter int MID_W   = 2,
  parameter int NUM_CPU = 2
) (
  input  rgn_t [NUM_RGN-1:0]         rgn_i,
  input  logic [WORD_W-1:GRAN_LSB]   blk_i,
  input  logic [MID_W-1:0]           master_i,
  input  logic                       super_i,
  input  acc_type_e                  type_i,
  output logic [NUM_RGN-1:0]         grant_o
);
  logic is_cpu;
  assign is_cpu = master_i < MID_W'(NUM_CPU);

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
    logic ge_lo, le_hi, hit, right;
    logic [2:0] cpu_rwx;
    assign ge_lo   = blk_i >= rgn_i[g].lo;
    assign le_hi   = blk_i <= rgn_i[g].hi;
    assign hit     = rgn_i[g].vld && ge_lo && le_hi;
    assign cpu_rwx = super_i ? rgn_i[g].perm[2:0] : rgn_i[g].perm[5:3];

    always_comb begin
      right = 1'b0;
      if (is_cpu) begin
        unique case (type_i)
          ACC_READ:  right = cpu_rwx[0];
          ACC_WRITE: right = cpu_rwx[1];
          ACC_FETCH: right = cpu_rwx[2];
          default:   right = 1'b0;
        endcase
      end else begin
        unique case (type_i)
          ACC_READ, ACC_FETCH: right = rgn_i[g].perm[6];
          ACC_WRITE:           right = rgn_i[g].perm[7];
          default:             right = 1'b0;
        endcase
      end
    end
    assign grant_o[g] = hit && right;
  end
endmodule

// File: rtl/bus_prot_checker.sv
module bus_prot_checker
  import bpc_pkg::*;
#(
  parameter int NUM_RGN = 12,
  parameter int MID_W   = 2,
  parameter int NUM_CPU = 2,
  localparam int CFG_AW = $clog2(NUM_RGN) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              acc_valid_i,
  input  logic [31:0]       acc_addr_i,
  input  logic [MID_W-1:0]  acc_master_i,
  input  logic              acc_super_i,
  input  logic [1:0]        acc_type_i,
  output logic              resp_valid_o,
  output logic              resp_err_o
);
  rgn_t [NUM_RGN-1:0] rgn;
  logic [NUM_RGN-1:0] grant;
  logic resp_valid_q, resp_err_q;

  bpc_rgn_store #(.NUM_RGN(NUM_RGN), .CFG_AW(CFG_AW)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .rgn_o  (rgn)
  );

  bpc_rgn_eval #(.NUM_RGN(NUM_RGN), .MID_W(MID_W), .NUM_CPU(NUM_CPU)) u_eval (
    .rgn_i   (rgn),
    .blk_i   (acc_addr_i[WORD_W-1:GRAN_LSB]),
    .master_i(acc_master_i),
    .super_i (acc_super_i),
    .type_i  (acc_type_e'(acc_type_i)),
    .grant_o (grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_q <= 1'b0;
      resp_err_q   <= 1'b0;
    end else begin
      resp_valid_q <= acc_valid_i;
      resp_err_q   <= acc_valid_i && !(|grant);
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_err_o   = resp_err_q;
endmodule

// File: rtl/bpc_sva.sv
module bpc_sva #(
  parameter int CFG_AW = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic [31:0]       cfg_wdata_i,
  input logic              acc_valid_i,
  input logic [1:0]        acc_type_i,
  input logic              resp_valid_o,
  input logic              resp_err_o
);
  // set once any enable write has been seen since reset
  logic seen_en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_en_q <= 1'b0;
    else if (cfg_we_i && cfg_addr_i[1:0] == 2'd3 && cfg_wdata_i[0]) seen_en_q <= 1'b1;
  end

  assert_resp_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> resp_valid_o);
  assert_resp_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !resp_valid_o);
  assert_err_qualified_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_err_o |-> resp_valid_o);
  assert_rsvd_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_type_i == 2'd3) |=> resp_err_o);
  assert_all_disabled_err_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !seen_en_q) |=> resp_err_o);
endmodule

bind bus_prot_checker bpc_sva #(.CFG_AW(CFG_AW)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .acc_valid_i (acc_valid_i),
  .acc_type_i  (acc_type_i),
  .resp_valid_o(resp_valid_o),
  .resp_err_o  (resp_err_o)
);

// File: tb/bus_prot_checker_bench.sv
`timescale 1ns/100ps
module bus_prot_checker_bench;
  localparam int NR   = 12;
  localparam int MW   = 2;
  localparam int NCPU = 2;
  localparam int CAW  = $clog2(NR) + 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [CAW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [MW-1:0] acc_master = '0;
  logic acc_super = 1'b0;
  logic [1:0] acc_type = '0;
  logic resp_valid, resp_err;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [26:0] m_lo [NR];
  logic [26:0] m_hi [NR];
  logic [7:0]  m_perm [NR];
  logic        m_vld [NR];

  always #2.5 clk = ~clk;

  bus_prot_checker #(.NUM_RGN(NR), .MID_W(MW), .NUM_CPU(NCPU)) u_bus_prot_checker (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .acc_master_i(acc_master), .acc_super_i(acc_super), .acc_type_i(acc_type),
    .resp_valid_o(resp_valid), .resp_err_o(resp_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference verdict built from R2..R6, R9
  function automatic logic exp_err(input logic [31:0] a, input int m, input logic s, input logic [1:0] t);
    logic ok = 1'b0;
    for (int k = 0; k < NR; k++) begin
      logic hit, r;
      hit = m_vld[k] && a[31:5] >= m_lo[k] && a[31:5] <= m_hi[k];
      if (t == 2'd3) r = 1'b0;
      else if (m < NCPU) r = m_perm[k][(s ? 0 : 3) + t];
      else r = (t == 2'd1) ? m_perm[k][7] : m_perm[k][6];
      if (hit && r) ok = 1'b1;
    end
    return !ok;
  endfunction

  task automatic cfg_write(input int idx, input int w, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CAW'(idx * 4 + w); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < NR) begin  // R7 model; R10: higher indices ignored
      case (w)
        0: begin m_lo[idx] = d[31:5]; m_vld[idx] = 1'b0; end
        1: begin m_hi[idx] = d[31:5]; m_vld[idx] = 1'b0; end
        2: begin m_perm[idx] = d[7:0]; m_vld[idx] = 1'b0; end
        default: m_vld[idx] = d[0];
      endcase
    end
  endtask

  task automatic access(input logic [31:0] a, input int m, input logic s, input logic [1:0] t, input string req);
    logic e;
    e = exp_err(a, m, s, t);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_master = MW'(m); acc_super = s; acc_type = t;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(resp_valid === 1'b1, "R8 resp_valid", 32'(resp_valid), 32'd1);
    chk(resp_err === e, req, 32'(resp_err), 32'(e));
  endtask

  task automatic sweep_region(input int k, input string req);
    logic [31:0] st, en, pts [6];
    st = {m_lo[k], 5'h00};
    en = {m_hi[k], 5'h1F};
    pts[0] = st; pts[1] = st - 1; pts[2] = en; pts[3] = en + 1;
    pts[4] = st + (en - st) / 2; pts[5] = st + 3;
    for (int p = 0; p < 6; p++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          for (int t = 0; t < 4; t++)
            access(pts[p], m, s[0], t[1:0], req);
  endtask

  initial begin
    for (int k = 0; k < NR; k++) begin
      m_lo[k] = '0; m_hi[k] = '0; m_perm[k] = '0; m_vld[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(resp_valid === 1'b0 && resp_err === 1'b0, "R1 outputs in reset", {resp_valid, resp_err}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(resp_valid === 1'b0 && resp_err === 1'b0, "R1 outputs after reset", {resp_valid, resp_err}, 0);
    // R1: everything disabled
    for (int t = 0; t < 4; t++) access(32'h0000_0100, 0, 1'b1, t[1:0], "R1 disabled after reset");
    access(32'hFFFF_FFFF, 3, 1'b0, 2'd0, "R1 disabled after reset");

    // overlapping staircase; region 5 left disabled, region 11 is a single 32-byte block at top
    for (int k = 0; k < NR; k++) begin
      logic [31:0] st, en;
      st = (k == NR - 1) ? 32'hFFFF_FFE0 : 32'(k * 32'h400);
      en = (k == NR - 1) ? 32'hFFFF_FFFF : 32'(k * 32'h400 + 32'h5FF);
      cfg_write(k, 3, 32'h1);
      cfg_write(k, 0, st | 32'h1F);  // low bits of a bound are ignored (R2)
      cfg_write(k, 1, en);
      cfg_write(k, 2, (k == 7) ? 32'hFF : 32'((k * 37 + 5) & 8'hFF));
      cfg_write(k, 3, (k == 5) ? 32'h0 : 32'h1);
    end
    for (int k = 0; k < NR; k++) sweep_region(k, "R2 R3 R4 R5 R6 R9 verdict");

    // R7: editing a bound disables the region, re-enable restores it
    cfg_write(2, 1, {m_hi[2], 5'h00});
    sweep_region(2, "R7 disabled by bound write");
    cfg_write(2, 3, 32'h1);
    sweep_region(2, "R7 re-enabled");
    cfg_write(7, 2, 32'hFF);
    sweep_region(7, "R7 disabled by perm write");
    cfg_write(7, 3, 32'h1);

    // R10: out-of-range indices change nothing
    for (int i = NR; i < (1 << (CAW - 2)); i++)
      for (int w = 0; w < 4; w++) cfg_write(i, w, 32'hFFFF_FFFF);
    sweep_region(0, "R10 ignored index");
    sweep_region(7, "R10 ignored index");
    sweep_region(11, "R10 ignored index");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule